// File: doc/BRIEF.md
# Read-Sequence Nonvolatile Command Detector

This block sits beside a byte-wide asynchronous SRAM port with a 13-bit address. It turns a fixed series of six ordinary read accesses into a save command or a restore command for a nonvolatile backing array. The address, write enable and chip enable are brought into the clock domain through a short synchronizer chain. Each falling edge of chip enable counts as one access, and the block checks that access against the next expected address in the series.

The first five accesses of a series must be reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order. The sixth access decides the command: 0x0F0F requests a save and 0x0F0E requests a restore. Any other sixth address, including the reserved factory-test code 0x139C, issues nothing. A write, an unexpected address or a repeated address aborts the series. A read of 0x0000 is never discarded: it always begins a new series.

A command leaves the block as a single-cycle pulse on `store_req` or `recall_req`. While the nonvolatile engine reports `busy`, the tracker is held at its idle step and accesses are not counted.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: After reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, a sixth read of 0x0F0F drives `store_req` high for exactly one clock cycle, and `recall_req` stays low.
- R2: The same five-read prefix followed by a read of 0x0F0E drives `recall_req` high for exactly one cycle, and `store_req` stays low. The two outputs are never high together.
- R3: A sixth read of 0x0F0F/0x0F0E's reserved neighbour 0x139C issues no command and returns the tracker to idle. A following series that omits the 0x0000 step then issues nothing.
- R4: An access taken with `we_n` low (a write) at any step aborts the series. The remaining steps then issue nothing.
- R5: An access whose address is not the next expected one aborts the series.
- R6: Two consecutive accesses to the same address abort the series, because the repeat is out of order.
- R7: `oe_n` has no effect on recognition. A series run with `oe_n` high gives the same command as one run with it low.
- R8: An access is counted only on a falling edge of `ce_n`. Address changes while `ce_n` is held low or held high count as no access.
- R9: A read of 0x0000 that aborts a series, or arrives after an abort, is taken as step one of a new series.
- R10: While `busy` is high, accesses are ignored and the tracker is held idle. Steps completed before `busy` rose do not survive it.
- R11: After reset, both request outputs are low.
- R12: A request pulse appears at the rising clock edge number SYNC_STAGES+1 after the sixth falling edge of `ce_n` is applied. With the default SYNC_STAGES=2, this is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low; its falling edge strobes an access |
| we_n | input | 1 | Write enable, active low; high marks a read |
| oe_n | input | 1 | Output enable, active low; does not affect detection |
| addr | input | ADDR_W (13) | Access address |
| busy | input | 1 | High while a nonvolatile transfer is running |
| store_req | output | 1 | One-cycle save command pulse |
| recall_req | output | 1 | One-cycle restore command pulse |

## Verification
The hardest state to reach from the ports is a tracker that has aborted part-way through and must decide whether the aborting access is itself a fresh first step. The stimulus reaches it with series that mix repeated 0x0000 reads and a partial prefix followed by 0x0000. Only a full command pulse afterwards shows that the restart took hold. The busy case is reached by completing three steps, raising `busy` for the rest of the series, and then lowering it and replaying only the tail of the series. No pulse must appear in either phase.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
   localparam int unsigned CODE_W     = 13;
   localparam int unsigned PREFIX_LEN = 5;

   localparam logic [CODE_W-1:0] STORE_CODE  = 13'h0F0F;
   localparam logic [CODE_W-1:0] RECALL_CODE = 13'h0F0E;
   localparam logic [CODE_W-1:0] TEST_CODE   = 13'h139C;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_STORE  = 2'd1,
      CMD_RECALL = 2'd2,
      CMD_TEST   = 2'd3
   } cmd_e;

   // Expected address for prefix step i (order is behaviour)
   function automatic logic [CODE_W-1:0] prefix_code(input int unsigned i);
      case (i)
         0:       return 13'h0000;
         1:       return 13'h1555;
         2:       return 13'h0AAA;
         3:       return 13'h1FFF;
         default: return 13'h10F0;
      endcase
   endfunction
endpackage

// File: rtl/nvcmd_strobe.sv
// Synchronizes the bus bundle and flags chip-enable falling edges.
module nvcmd_strobe #(
   parameter int unsigned ADDR_W      = 13,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              fall,
   output logic              rd_s,
   output logic [ADDR_W-1:0] addr_s
);
   localparam int unsigned BW = ADDR_W + 2;

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("nvcmd_strobe: SYNC_STAGES must be at least 1");
   end

   logic [BW-1:0] pipe [SYNC_STAGES];
   logic          ce_prev;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      logic [BW-1:0] din;
      if (s == 0) begin : g_first
         assign din = {ce_n, we_n, addr};
      end else begin : g_next
         assign din = pipe[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= {2'b11, {ADDR_W{1'b0}}};
         else        pipe[s] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_prev <= 1'b1;
      else        ce_prev <= pipe[SYNC_STAGES-1][BW-1];
   end

   assign fall   = ce_prev & ~pipe[SYNC_STAGES-1][BW-1];
   assign rd_s   = pipe[SYNC_STAGES-1][BW-2];
   assign addr_s = pipe[SYNC_STAGES-1][ADDR_W-1:0];
endmodule

// File: rtl/nvcmd_match.sv
// Compares the sampled address against every prefix step and final code.
module nvcmd_match
   import nvcmd_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  logic [ADDR_W-1:0]     addr,
   output logic [PREFIX_LEN-1:0] step_hit,
   output cmd_e                  final_cmd
);
   if (ADDR_W < CODE_W) begin : g_bad_width
      $error("nvcmd_match: ADDR_W must cover the 13-bit codes");
   end

   for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_cmp
      assign step_hit[i] = (addr == ADDR_W'(prefix_code(i)));
   end

   always_comb begin
      if (addr == ADDR_W'(STORE_CODE))       final_cmd = CMD_STORE;
      else if (addr == ADDR_W'(RECALL_CODE)) final_cmd = CMD_RECALL;
      else if (addr == ADDR_W'(TEST_CODE))   final_cmd = CMD_TEST;
      else                                   final_cmd = CMD_NONE;
   end
endmodule

// File: rtl/nvcmd_tracker.sv
// Step counter through the series; emits registered command pulses.
module nvcmd_tracker
   import nvcmd_pkg::*;
#(
   parameter int unsigned STEP_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  strobe,
   input  logic                  rd,
   input  logic                  busy,
   input  logic [PREFIX_LEN-1:0] step_hit,
   input  cmd_e                  final_cmd,
   output logic [STEP_W-1:0]     step,
   output logic                  store_req,
   output logic                  recall_req
);
   if ((1 << STEP_W) <= PREFIX_LEN) begin : g_bad_step_w
      $error("nvcmd_tracker: STEP_W too narrow for the prefix length");
   end

   logic [STEP_W-1:0] step_nxt;
   logic              st_nxt, rc_nxt, exp_hit;
   logic [STEP_W-1:0] restart;

   always_comb begin
      exp_hit = 1'b0;
      for (int i = 0; i < PREFIX_LEN; i++) begin
         if (step == STEP_W'(i)) exp_hit = step_hit[i];
      end
   end

   // A read of the first code always opens a new series
   assign restart = step_hit[0] ? STEP_W'(1) : '0;

   always_comb begin
      step_nxt = step;
      st_nxt   = 1'b0;
      rc_nxt   = 1'b0;
      if (busy) begin
         step_nxt = '0;
      end else if (strobe) begin
         if (!rd) begin
            step_nxt = '0;
         end else if (step == STEP_W'(PREFIX_LEN)) begin
            st_nxt   = (final_cmd == CMD_STORE);
            rc_nxt   = (final_cmd == CMD_RECALL);
            step_nxt = restart;
         end else if (exp_hit) begin
            step_nxt = step + STEP_W'(1);
         end else begin
            step_nxt = restart;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step       <= '0;
         store_req  <= 1'b0;
         recall_req <= 1'b0;
      end else begin
         step       <= step_nxt;
         store_req  <= st_nxt;
         recall_req <= rc_nxt;
      end
   end
endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
   import nvcmd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 13,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy,
   output logic              store_req,
   output logic              recall_req
);
   localparam int unsigned STEP_W = $clog2(PREFIX_LEN + 1);

   logic                  ce_fall;
   logic                  rd_s;
   logic [ADDR_W-1:0]     addr_s;
   logic [PREFIX_LEN-1:0] step_hit;
   cmd_e                  final_cmd;
   logic [STEP_W-1:0]     trk_step;
   logic                  unused_oe;

   // Output enable plays no part in recognition
   assign unused_oe = oe_n;

   nvcmd_strobe #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_strobe (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
      .fall(ce_fall), .rd_s(rd_s), .addr_s(addr_s)
   );

   nvcmd_match #(.ADDR_W(ADDR_W)) u_match (
      .addr(addr_s), .step_hit(step_hit), .final_cmd(final_cmd)
   );

   nvcmd_tracker #(.STEP_W(STEP_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .strobe(ce_fall), .rd(rd_s), .busy(busy),
      .step_hit(step_hit), .final_cmd(final_cmd), .step(trk_step),
      .store_req(store_req), .recall_req(recall_req)
   );
endmodule

// File: rtl/nvcmd_seq_chk.sv
module nvcmd_seq_chk #(
   parameter int unsigned STEP_W = 3,
   parameter int unsigned PREFIX = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              strobe,
   input logic              rd_s,
   input logic [STEP_W-1:0] step,
   input logic              store_req,
   input logic              recall_req
);
   p_store_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |=> !store_req);

   p_recall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |=> !recall_req);

   p_req_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_req, recall_req}));

   // R4 and R8: a request needs a read strobe one cycle before
   p_req_from_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || recall_req) |-> $past(strobe && rd_s));

   p_busy_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> (step == '0));

   p_busy_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || recall_req) |-> !$past(busy));

   p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step <= STEP_W'(PREFIX));
endmodule

bind nvcmd_seq_detect nvcmd_seq_chk #(.STEP_W(STEP_W), .PREFIX(nvcmd_pkg::PREFIX_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .strobe(ce_fall), .rd_s(rd_s),
   .step(trk_step), .store_req(store_req), .recall_req(recall_req)
);

// File: tb/nvcmd_seq_detect_tb.sv
module nvcmd_seq_detect_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, busy = 1'b0;
   logic [12:0] addr = '0;
   logic        store_req, recall_req;
   int          total = 0, bad = 0;
   int          st_cnt = 0, rc_cnt = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   nvcmd_seq_detect u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .busy(busy), .store_req(store_req), .recall_req(recall_req)
   );

   always @(posedge clk) begin
      if (store_req)  st_cnt++;
      if (recall_req) rc_cnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clr();
      @(negedge clk);
      st_cnt = 0;
      rc_cnt = 0;
   endtask

   task automatic acc(input logic [12:0] a, input logic we = 1'b1);
      @(negedge clk);
      addr = a; we_n = we; ce_n = 1'b0;
      repeat (4) @(negedge clk);
      ce_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic prefix();
      acc(13'h0000); acc(13'h1555); acc(13'h0AAA); acc(13'h1FFF); acc(13'h10F0);
   endtask

   task automatic expect_cnt(input string req, input int st, input int rc);
      repeat (4) @(negedge clk);
      chk(st_cnt == st, {req, " store"}, st_cnt, st);
      chk(rc_cnt == rc, {req, " recall"}, rc_cnt, rc);
   endtask

   task automatic t_reset_r11();
      @(negedge clk);
      chk(store_req == 1'b0, "R11 store", int'(store_req), 0);
      chk(recall_req == 1'b0, "R11 recall", int'(recall_req), 0);
   endtask

   task automatic t_store_r1();
      clr(); prefix(); acc(13'h0F0F);
      expect_cnt("R1", 1, 0);
   endtask

   task automatic t_recall_r2();
      clr(); prefix(); acc(13'h0F0E);
      expect_cnt("R2", 0, 1);
   endtask

   task automatic t_test_code_r3();
      clr(); prefix(); acc(13'h139C);
      acc(13'h1555); acc(13'h0AAA); acc(13'h1FFF); acc(13'h10F0); acc(13'h0F0F);
      expect_cnt("R3", 0, 0);
   endtask

   task automatic t_write_r4();
      clr();
      acc(13'h0000); acc(13'h1555); acc(13'h0AAA, 1'b0);
      acc(13'h1FFF); acc(13'h10F0); acc(13'h0F0F);
      expect_cnt("R4 mid", 0, 0);
      clr(); prefix(); acc(13'h0F0F, 1'b0);
      expect_cnt("R4 last", 0, 0);
   endtask

   task automatic t_wrong_r5();
      clr();
      acc(13'h0000); acc(13'h1555); acc(13'h0AAB);
      acc(13'h1FFF); acc(13'h10F0); acc(13'h0F0F);
      expect_cnt("R5", 0, 0);
   endtask

   task automatic t_repeat_r6();
      clr();
      acc(13'h0000); acc(13'h1555); acc(13'h1555);
      acc(13'h0AAA); acc(13'h1FFF); acc(13'h10F0); acc(13'h0F0E);
      expect_cnt("R6", 0, 0);
   endtask

   task automatic t_oe_r7();
      clr();
      oe_n = 1'b1;
      prefix(); acc(13'h0F0F);
      oe_n = 1'b0;
      expect_cnt("R7", 1, 0);
   endtask

   task automatic t_strobe_r8();
      clr(); prefix();
      // ce_n held high while the address walks: nothing counted
      @(negedge clk); addr = 13'h0F0F;
      repeat (5) @(negedge clk); addr = 13'h0F0E;
      repeat (5) @(negedge clk);
      chk(st_cnt == 0 && rc_cnt == 0, "R8 no fall", st_cnt + rc_cnt, 0);
      // ce_n held low across an address change: one access only
      @(negedge clk); addr = 13'h0F0F; ce_n = 1'b0;
      repeat (5) @(negedge clk); addr = 13'h0000;
      repeat (5) @(negedge clk); addr = 13'h1555;
      repeat (5) @(negedge clk); ce_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(st_cnt == 1, "R8 one strobe", st_cnt, 1);
      // tracker ended idle: tail of a series alone issues nothing
      acc(13'h0AAA); acc(13'h1FFF); acc(13'h10F0); acc(13'h0F0F);
      expect_cnt("R8 tail", 1, 0);
   endtask

   task automatic t_restart_r9();
      clr();
      acc(13'h0000); acc(13'h0000); acc(13'h1555); acc(13'h0AAA);
      acc(13'h1FFF); acc(13'h10F0); acc(13'h0F0F);
      expect_cnt("R9 repeat zero", 1, 0);
      clr();
      acc(13'h0000); acc(13'h1555); acc(13'h0AAA); acc(13'h0000);
      acc(13'h1555); acc(13'h0AAA); acc(13'h1FFF); acc(13'h10F0); acc(13'h0F0E);
      expect_cnt("R9 mid abort", 0, 1);
   endtask

   task automatic t_busy_r10();
      clr();
      acc(13'h0000); acc(13'h1555); acc(13'h0AAA);
      @(negedge clk); busy = 1'b1;
      acc(13'h1FFF); acc(13'h10F0); acc(13'h0F0F);
      expect_cnt("R10 during", 0, 0);
      @(negedge clk); busy = 1'b0;
      acc(13'h1FFF); acc(13'h10F0); acc(13'h0F0F);
      expect_cnt("R10 after", 0, 0);
   endtask

   task automatic t_latency_r12();
      clr(); prefix();
      @(negedge clk); addr = 13'h0F0F; we_n = 1'b1; ce_n = 1'b0;
      @(negedge clk);
      chk(store_req == 1'b0, "R12 edge1", int'(store_req), 0);
      @(negedge clk);
      chk(store_req == 1'b0, "R12 edge2", int'(store_req), 0);
      @(negedge clk);
      chk(store_req == 1'b1, "R12 edge3", int'(store_req), 1);
      @(negedge clk);
      chk(store_req == 1'b0, "R12 edge4", int'(store_req), 0);
      ce_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_r11();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_r11();
      t_store_r1();
      t_recall_r2();
      t_test_code_r3();
      t_write_r4();
      t_wrong_r5();
      t_repeat_r6();
      t_oe_r7();
      t_strobe_r8();
      t_restart_r9();
      t_busy_r10();
      t_latency_r12();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule